// File: doc/BRIEF.md
# Post-Update Load/Store Address Unit

This block carries out one scalar integer load or store for a 64-bit core. It takes an operation that has already been decoded, the register values it needs and the 16-bit immediate field. It then drives a single request/response memory port and returns two results: the load result with its own write enable, and the updated base register with its own write enable.

The normal mode is post-update. The access goes to the base register exactly as it stands. The offset is either a sign-extended displacement or a second register, and the base-plus-offset sum is used only as the new base after the access. A legacy pre-update mode is selected per operation. In that mode the sum is used both as the access address and as the new base.

The block works on one operation at a time. It takes a new operation only while it signals that it is idle. It holds its request until the memory grants it. It reports completion one cycle after the read or write response arrives. No status registers are touched.

Top module: `postupd_lsu`

## Requirements
- R1: In post-update mode (`opPreUpdate`=0), `memAddr` equals the RA value that was captured when the operation was accepted.
- R2: With an immediate offset (`opIndexed`=0) and a size other than 8 bytes, `raData` equals RA plus `opImm` sign-extended from 16 bits.
- R3: With an indexed offset (`opIndexed`=1), `raData` equals RA plus RB for every size.
- R4: With an immediate offset and size code 3 (8 bytes), the offset is `opImm[15:2]` followed by two zero bits, sign-extended. The two low bits of `opImm` have no effect on `raData`.
- R5: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A load takes that many bytes from `memRdata`, starting at byte lane `memAddr[2:0]`, and returns them in `rtData`. Lanes beyond lane 7 read as zero. If `opSigned`=1 and the size is 2 or 4 bytes, the result is sign-extended. Otherwise it is zero-extended. An 8-byte load returns all 64 bits.
- R6: A store drives `memWe`=1 and places the low 1, 2, 4 or 8 bytes of RS in `memWdata`, starting at byte lane `memAddr[2:0]`. All other bytes are zero. A load drives `memWe`=0.
- R7: `memBe` has one bit set for each accessed lane, starting at bit `memAddr[2:0]`. Lanes past bit 7 are dropped, and a misaligned address is passed through without any fault.
- R8: In pre-update mode (`opPreUpdate`=1), `memAddr` and `raData` both equal RA plus the offset.
- R9: An operation is accepted only in a cycle where `opValid` and `opReady` are both high. Once raised, `memReq` stays high with a stable `memAddr` until `memGnt` is seen.
- R10: `done` and `raWe` rise together for exactly one cycle, in the cycle after `memRvalid`. `rtWe` rises with them for loads and never rises for stores.
- R11: A load whose `opRtIdx` equals `opRaIdx` raises `badForm` with `done` and suppresses `rtWe`, but still writes the new RA. A store never raises `badForm`.
- R12: While an operation is in flight, `opReady` is low and changes on the operation inputs have no effect on its address or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Block is idle and takes an offered operation |
| opSize | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| opStore | input | 1 | 1 = store, 0 = load |
| opSigned | input | 1 | Sign-extend 2- and 4-byte loads |
| opIndexed | input | 1 | Offset taken from RB instead of the immediate |
| opPreUpdate | input | 1 | Legacy mode: access at base plus offset |
| opRtIdx | input | 5 | Number of the load target register |
| opRaIdx | input | 5 | Number of the base register |
| opRa | input | 64 | Base register value |
| opRb | input | 64 | Index register value |
| opRs | input | 64 | Store source value |
| opImm | input | 16 | Immediate field |
| memReq | output | 1 | Memory request |
| memGnt | input | 1 | Memory accepts the request |
| memAddr | output | 64 | Access address |
| memWe | output | 1 | Write request |
| memBe | output | 8 | Byte-lane enables |
| memWdata | output | 64 | Lane-placed write data |
| memRvalid | input | 1 | Memory response |
| memRdata | input | 64 | Read data, valid with `memRvalid` |
| done | output | 1 | Operation complete, one cycle |
| rtWe | output | 1 | Write enable for the load target |
| rtData | output | 64 | Extended load result |
| raWe | output | 1 | Write enable for the base register |
| raData | output | 64 | New base value |
| badForm | output | 1 | Load whose target is its own base |

## Verification
The checker watches the handshake rules on every cycle: the request is held with a stable address until it is granted, `done` lasts exactly one cycle and follows a response, `raWe` matches `done`, `rtWe` never appears on a bad form, and the block is never idle while it is requesting. The arithmetic can only be shown by the bench's scenarios against its own reference functions. That covers the effective address in both modes, the three offset forms, the lane placement of data and enables, the sign and zero extension, and the bad-form suppression. The same holds for ignoring operation inputs while busy.

// File: rtl/pu_pkg.sv
package pu_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } puState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operation and operands
    logic grab;     // latch read data
  } dpStrobe_t;

endpackage

// File: rtl/pu_ctrl.sv
module pu_ctrl
  import pu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      opValid,
  input  logic      memGnt,
  input  logic      memRvalid,
  output logic      opReady,
  output logic      memReq,
  output logic      fin,
  output dpStrobe_t strobe
);

  puState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt       = state;
    strobe.capture = 1'b0;
    strobe.grab    = 1'b0;
    case (state)
      ST_IDLE: if (opValid) begin
        strobe.capture = 1'b1;
        stateNxt       = ST_REQ;
      end
      ST_REQ:  if (memGnt) stateNxt = ST_WAIT;
      ST_WAIT: if (memRvalid) begin
        strobe.grab = 1'b1;
        stateNxt    = ST_FIN;
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign opReady = (state == ST_IDLE);
  assign memReq  = (state == ST_REQ);
  assign fin     = (state == ST_FIN);

endmodule

// File: rtl/pu_datapath.sv
module pu_datapath
  import pu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        opSize,
  input  logic              opStore,
  input  logic              opSigned,
  input  logic              opIndexed,
  input  logic              opPreUpdate,
  input  logic [REGW-1:0]   opRtIdx,
  input  logic [REGW-1:0]   opRaIdx,
  input  logic [XLEN-1:0]   opRa,
  input  logic [XLEN-1:0]   opRb,
  input  logic [XLEN-1:0]   opRs,
  input  logic [15:0]       opImm,
  input  logic [XLEN-1:0]   memRdata,
  output logic [XLEN-1:0]   memAddr,
  output logic              memWe,
  output logic [XLEN/8-1:0] memBe,
  output logic [XLEN-1:0]   memWdata,
  output logic [XLEN-1:0]   rtData,
  output logic [XLEN-1:0]   raData,
  output logic              loadQ,
  output logic              badQ
);

  localparam int LANES = XLEN / 8;
  localparam int LW    = $clog2(LANES);
  localparam int SHW   = LW + 3;

  logic [XLEN-1:0] raQ, rbQ, rsQ, rdataQ;
  logic [15:0]     immQ;
  accSize_e        sizeQ;
  logic            storeQ, signedQ, indexedQ, preQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      raQ      <= '0;
      rbQ      <= '0;
      rsQ      <= '0;
      immQ     <= '0;
      sizeQ    <= SZ_B;
      storeQ   <= 1'b0;
      signedQ  <= 1'b0;
      indexedQ <= 1'b0;
      preQ     <= 1'b0;
      badQ     <= 1'b0;
      rdataQ   <= '0;
    end else begin
      if (strobe.capture) begin
        raQ      <= opRa;
        rbQ      <= opRb;
        rsQ      <= opRs;
        immQ     <= opImm;
        sizeQ    <= accSize_e'(opSize);
        storeQ   <= opStore;
        signedQ  <= opSigned;
        indexedQ <= opIndexed;
        preQ     <= opPreUpdate;
        badQ     <= !opStore && (opRtIdx == opRaIdx);
      end
      if (strobe.grab) rdataQ <= memRdata;
    end
  end

  // offset selection: register, word-scaled immediate, or plain immediate
  logic [XLEN-1:0] offset, sum;
  always_comb begin
    if (indexedQ)          offset = rbQ;
    else if (sizeQ == SZ_D) offset = {{(XLEN-16){immQ[15]}}, immQ[15:2], 2'b00};
    else                   offset = {{(XLEN-16){immQ[15]}}, immQ};
  end

  assign sum     = raQ + offset;
  assign memAddr = preQ ? sum : raQ;
  assign raData  = sum;
  assign memWe   = storeQ;
  assign loadQ   = !storeQ;

  logic [LW-1:0]  laneOff;
  logic [LW:0]    nBytes;
  logic [SHW-1:0] shAmt;
  logic [XLEN-1:0] sizeMask;

  assign laneOff = memAddr[LW-1:0];
  assign nBytes  = (LW+1)'(1) << sizeQ;
  assign shAmt   = {laneOff, 3'b000};

  always_comb begin
    case (sizeQ)
      SZ_B:    sizeMask = XLEN'(8'hFF);
      SZ_H:    sizeMask = XLEN'(16'hFFFF);
      SZ_W:    sizeMask = XLEN'(32'hFFFF_FFFF);
      default: sizeMask = '1;
    endcase
  end

  // byte enables, one comparator pair per lane
  logic [LW:0] laneLo, laneHi;
  assign laneLo = {1'b0, laneOff};
  assign laneHi = laneLo + nBytes;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memBe[i] = ((LW+1)'(i) >= laneLo) && ((LW+1)'(i) < laneHi);
  end

  assign memWdata = (rsQ & sizeMask) << shAmt;

  // load extraction and extension
  logic [XLEN-1:0] loadRaw;
  assign loadRaw = (rdataQ >> shAmt) & sizeMask;

  always_comb begin
    rtData = loadRaw;
    if (signedQ) begin
      if (sizeQ == SZ_H) rtData = {{(XLEN-16){loadRaw[15]}}, loadRaw[15:0]};
      if (sizeQ == SZ_W) rtData = {{(XLEN-32){loadRaw[31]}}, loadRaw[31:0]};
    end
  end

endmodule

// File: rtl/postupd_lsu.sv
module postupd_lsu
  import pu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [1:0]        opSize,
  input  logic              opStore,
  input  logic              opSigned,
  input  logic              opIndexed,
  input  logic              opPreUpdate,
  input  logic [REGW-1:0]   opRtIdx,
  input  logic [REGW-1:0]   opRaIdx,
  input  logic [XLEN-1:0]   opRa,
  input  logic [XLEN-1:0]   opRb,
  input  logic [XLEN-1:0]   opRs,
  input  logic [15:0]       opImm,
  output logic              memReq,
  input  logic              memGnt,
  output logic [XLEN-1:0]   memAddr,
  output logic              memWe,
  output logic [XLEN/8-1:0] memBe,
  output logic [XLEN-1:0]   memWdata,
  input  logic              memRvalid,
  input  logic [XLEN-1:0]   memRdata,
  output logic              done,
  output logic              rtWe,
  output logic [XLEN-1:0]   rtData,
  output logic              raWe,
  output logic [XLEN-1:0]   raData,
  output logic              badForm
);

  dpStrobe_t strobe;
  logic      fin, loadQ, badQ;

  pu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .memGnt    (memGnt),
    .memRvalid (memRvalid),
    .opReady   (opReady),
    .memReq    (memReq),
    .fin       (fin),
    .strobe    (strobe)
  );

  pu_datapath #(.XLEN(XLEN), .REGW(REGW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opSize      (opSize),
    .opStore     (opStore),
    .opSigned    (opSigned),
    .opIndexed   (opIndexed),
    .opPreUpdate (opPreUpdate),
    .opRtIdx     (opRtIdx),
    .opRaIdx     (opRaIdx),
    .opRa        (opRa),
    .opRb        (opRb),
    .opRs        (opRs),
    .opImm       (opImm),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWe       (memWe),
    .memBe       (memBe),
    .memWdata    (memWdata),
    .rtData      (rtData),
    .raData      (raData),
    .loadQ       (loadQ),
    .badQ        (badQ)
  );

  assign done    = fin;
  assign raWe    = fin;
  assign rtWe    = fin && loadQ && !badQ;
  assign badForm = fin && badQ;

endmodule

// File: rtl/postupd_lsu_chk.sv
module postupd_lsu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            opReady,
  input logic            memReq,
  input logic            memGnt,
  input logic [XLEN-1:0] memAddr,
  input logic            memRvalid,
  input logic            done,
  input logic            rtWe,
  input logic            raWe,
  input logic            badForm
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq);

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> $stable(memAddr));

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(opReady && memReq));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_after_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(memRvalid));

  // R10
  ra_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    raWe == done);

  // R11
  rt_not_bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtWe |-> done && !badForm);

  // R11
  bad_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    badForm |-> done);

endmodule

bind postupd_lsu postupd_lsu_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opReady   (opReady),
  .memReq    (memReq),
  .memGnt    (memGnt),
  .memAddr   (memAddr),
  .memRvalid (memRvalid),
  .done      (done),
  .rtWe      (rtWe),
  .raWe      (raWe),
  .badForm   (badForm)
);

// File: tb/postupd_lsu_test.sv
module postupd_lsu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opReady;
  logic [1:0]  opSize = '0;
  logic        opStore = 1'b0, opSigned = 1'b0, opIndexed = 1'b0, opPreUpdate = 1'b0;
  logic [4:0]  opRtIdx = '0, opRaIdx = '0;
  logic [63:0] opRa = '0, opRb = '0, opRs = '0;
  logic [15:0] opImm = '0;
  logic        memReq, memGnt = 1'b0, memWe, memRvalid = 1'b0;
  logic [63:0] memAddr, memWdata, memRdata = '0;
  logic [7:0]  memBe;
  logic        done, rtWe, raWe, badForm;
  logic [63:0] rtData, raData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  postupd_lsu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opSize(opSize), .opStore(opStore), .opSigned(opSigned),
    .opIndexed(opIndexed), .opPreUpdate(opPreUpdate),
    .opRtIdx(opRtIdx), .opRaIdx(opRaIdx), .opRa(opRa), .opRb(opRb),
    .opRs(opRs), .opImm(opImm), .memReq(memReq), .memGnt(memGnt),
    .memAddr(memAddr), .memWe(memWe), .memBe(memBe), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRdata(memRdata), .done(done), .rtWe(rtWe),
    .rtData(rtData), .raWe(raWe), .raData(raData), .badForm(badForm)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  function automatic logic [63:0] refOffset(logic idx, logic [1:0] sz, logic [63:0] rb, logic [15:0] imm);
    logic signed [63:0] s;
    if (idx) return rb;
    s = 64'(signed'(imm));
    if (sz == 2'd3) s = (64'(signed'(imm)) >>> 2) * 4;
    return 64'(s);
  endfunction

  function automatic logic [7:0] refBe(logic [2:0] off, int n);
    logic [7:0] b = '0;
    for (int k = 0; k < n; k++) if (int'(off) + k < 8) b[int'(off) + k] = 1'b1;
    return b;
  endfunction

  function automatic logic [63:0] refWdata(logic [2:0] off, int n, logic [63:0] rs);
    logic [63:0] w = '0;
    for (int k = 0; k < n; k++) if (int'(off) + k < 8) w[(int'(off) + k)*8 +: 8] = rs[k*8 +: 8];
    return w;
  endfunction

  function automatic logic [63:0] refRt(logic [2:0] off, int n, logic sgn, logic [63:0] rd);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) if (int'(off) + k < 8) r[k*8 +: 8] = rd[(int'(off) + k)*8 +: 8];
    if (sgn && (n == 2 || n == 4) && r[n*8-1])
      for (int k = n*8; k < 64; k++) r[k] = 1'b1;
    return r;
  endfunction

  task automatic runOp(input logic [1:0] sz, input logic st, input logic sg, input logic ix,
                       input logic pre, input logic [4:0] rt, input logic [4:0] ra,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] s,
                       input logic [15:0] imm, input logic [63:0] rd, input bit busyPoke);
    logic [63:0] sum, eAddr;
    int n;
    bit bad;
    n     = 1 << sz;
    sum   = a + refOffset(ix, sz, b, imm);
    eAddr = pre ? sum : a;
    bad   = !st && (rt == ra);
    while (!opReady) @(negedge clk);
    opValid = 1'b1; opSize = sz; opStore = st; opSigned = sg; opIndexed = ix;
    opPreUpdate = pre; opRtIdx = rt; opRaIdx = ra; opRa = a; opRb = b; opRs = s; opImm = imm;
    @(negedge clk);
    // R12: scramble inputs while busy
    if (busyPoke) begin
      chk(opReady == 1'b0, "R12 busy ready", 64'(opReady), 0);
      opRa = ~a; opRb = b + 64'd4096; opImm = ~imm; opPreUpdate = ~pre; opStore = ~st;
    end else opValid = 1'b0;
    while (!memReq) @(negedge clk);
    chk(memAddr == eAddr, pre ? "R8 addr" : "R1 addr", memAddr, eAddr);
    chk(memWe == st, "R6 we", 64'(memWe), 64'(st));
    chk(memBe == refBe(eAddr[2:0], n), "R7 be", 64'(memBe), 64'(refBe(eAddr[2:0], n)));
    if (st) chk(memWdata == refWdata(eAddr[2:0], n, s), "R6 wdata", memWdata, refWdata(eAddr[2:0], n, s));
    opValid = 1'b0;
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      chk(memReq && memAddr == eAddr, "R9 hold", memAddr, eAddr);
    end
    memGnt = 1'b1;
    @(negedge clk);
    memGnt = 1'b0;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(!done, "R10 early done", 64'(done), 0);
    end
    memRvalid = 1'b1; memRdata = rd;
    @(negedge clk);
    memRvalid = 1'b0; memRdata = $urandom();
    chk(done && raWe, "R10 done/raWe", {62'd0, done, raWe}, 64'd3);
    chk(rtWe == (!st && !bad), "R10 rtWe", 64'(rtWe), 64'(!st && !bad));
    chk(badForm == bad, "R11 badForm", 64'(badForm), 64'(bad));
    chk(raData == sum, ix ? "R3 newRa" : (sz == 2'd3 ? "R4 newRa" : "R2 newRa"), raData, sum);
    if (!st && !bad) chk(rtData == refRt(eAddr[2:0], n, sg, rd), "R5 rtData", rtData, refRt(eAddr[2:0], n, sg, rd));
    @(negedge clk);
    chk(!done && !raWe && !rtWe, "R10 one cycle", {61'd0, done, raWe, rtWe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(opReady && !memReq && !done && !raWe && !rtWe, "R9 reset state",
        {59'd0, opReady, memReq, done, raWe, rtWe}, 64'h10);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runOp(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 5'd4, 64'h1007, 0, 0, 16'hFFF0, 64'h8000_0000_0000_0000, 0); // R7 lane 7
    runOp(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 5'd4, 64'h2000, 0, 0, 16'h8003, 64'h0123_4567_89AB_CDEF, 0); // R4
    runOp(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 5'd3, 5'd4, 64'h2000, 0, 64'hDEAD_BEEF_0000_0001, 16'h0007, 0, 0); // R4 store
    runOp(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'd9, 5'd9, 64'h3004, 0, 0, 16'h0010, 64'h8765_4321_0000_0000, 0); // R11
    runOp(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd9, 5'd9, 64'h3004, 0, 64'hFFFF_FFFF_8001_0203, 16'h0010, 0, 0); // R11 store
    runOp(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd1, 5'd2, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFD, 0, 0, 64'hAA_BBCC, 0); // R8 neg RB
    runOp(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd1, 5'd2, 64'h5002, 64'd6, 0, 0, 64'h0000_0000_F00D_0000, 1); // R12
    runOp(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1, 5'd2, 64'h6000, 0, 64'h1122_3344_5566_7788, 16'hFFFC, 0, 1); // R8 store, R12
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a = {$urandom(), $urandom()};
      logic [4:0] rt = 5'($urandom_range(0, 31));
      logic [4:0] ra = ($urandom_range(0, 7) == 0) ? rt : 5'($urandom_range(0, 31));
      runOp(2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
            rt, ra, a, {{32{1'b0}}, $urandom()} - 64'h8000_0000, {$urandom(), $urandom()},
            16'($urandom()), {$urandom(), $urandom()}, ($urandom_range(0, 9) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule